// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block manages a bank of up to 32 general-purpose I/O lines. Software reaches it through a plain register port with one-cycle write and read strobes. It sets the driven level and the drive enable of each line, and reads back the pin levels. Each line can be set up as an interrupt source that fires on a rising or falling edge, or on a high or low level.

Each pin is passed through a two-flop synchronizer. The synchronized sample is compared with the configured trigger condition, and every hit is latched into a per-line status bit. A hit is latched even when the line's interrupt enable bit is clear. Level hits are latched the same way as edges. A status bit stays set until software writes a 1 to the matching bit of the clear register.

A single summary interrupt is high whenever any status bit is set together with its enable bit. Because this output is a level, a line that triggers again while software is still servicing it keeps the summary asserted, so no event is lost.

Top module: `gpio_irq_bank`

## Requirements
- R1: `pin_out` carries the output-value register and `pin_oe` carries the output-enable register, bit per line, from the clock edge that samples the write. `pin_oe` changes only through a write to the output-enable address.
- R2: The register map uses word addresses on `addr`: 0 = input levels (read-only), 1 = output value, 2 = output enable, 3 = status (read-only), 4 = clear (write-only, reads 0), 5 = interrupt enable, 6 = trigger type (1 = edge, 0 = level), 7 = polarity (1 = rising/high, 0 = falling/low). `rdata` is loaded at the edge that samples `rd_en` and holds its value until the next read.
- R3: Reading address 0 returns each pin's level after two synchronizer flops. A change on `pin_in` is visible to a read strobe issued two clock edges after the change.
- R4: A trigger hit sets the line's status bit whether or not that line's enable bit is set.
- R5: Writing the clear address clears each status bit whose `wdata` bit is 1. Status bits whose `wdata` bit is 0 are left unchanged.
- R6: In edge mode with polarity 1, a 0-to-1 transition of the synchronized pin sets status. With polarity 0, a 1-to-0 transition sets status. The opposite edge sets nothing.
- R7: In level mode, a pin at the active level sets status, and the bit stays set after the pin returns inactive until it is cleared. With the all-zero reset configuration, every line is low-level triggered, so low pins latch status right after reset.
- R8: `irq_out` is high exactly when some line has both its status bit and its enable bit set. It is low when the enable register is zero or the status register is zero.
- R9: When a trigger hit and a clear write address the same bit in the same cycle, the status bit ends up set.
- R10: Synchronous active-low reset sets every register to zero, so `pin_oe`, `pin_out`, `irq_out` and `rdata` are 0.
- R11: Bits at or above `NUM_LINES` read as zero in every register, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_LINES | Pin levels from the pads |
| pin_out | output | NUM_LINES | Level to drive on each pin |
| pin_oe | output | NUM_LINES | Drive enable per pin |
| irq_out | output | 1 | Level summary interrupt |

## Verification
Two things can land on the same status bit in the same clock cycle: a fresh trigger hit and a software clear of that bit. The bench provokes this in two ways. First, it holds a level-triggered pin active while clearing its bit. Second, it times a clear write so that it is sampled on the exact edge where a rising pin's edge hit is latched; this edge is found by counting the two synchronizer flops and the history flop. In both cases the status read that follows must show the bit still set. A clear issued after the pin has gone inactive must show the bit empty.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank: register width and word addresses.
// Assumes a 32-bit register port with at most 32 lines per bank.
package gpio_bank_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL = 3'd0,
        RA_DRIVE = 3'd1,
        RA_OEN   = 3'd2,
        RA_STAT  = 3'd3,
        RA_CLR   = 3'd4,
        RA_IEN   = 3'd5,
        RA_KIND  = 3'd6,
        RA_POL   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer per line plus a history flop for edge detection.
// Assumes pin_in is asynchronous to clk; outputs are clk-domain samples.
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] smp_cur,
    output logic [N-1:0] smp_prev
);
    logic [N-1:0] meta_q;

    // Shift pins through two sync stages and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            smp_cur  <= '0;
            smp_prev <= '0;
        end else begin
            meta_q   <= pin_in;
            smp_cur  <= meta_q;
            smp_prev <= smp_cur;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
// Per-line trigger evaluation: edge or level, active high/rising or low/falling.
// Pure combinational; assumes synchronized current and previous samples.
module gpio_trig_detect #(
    parameter int N = 32
) (
    input  logic [N-1:0] smp_cur,
    input  logic [N-1:0] smp_prev,
    input  logic [N-1:0] kind_edge,
    input  logic [N-1:0] pol_high,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic rise_w, fall_w, lvl_w;
        assign rise_w = smp_cur[i] & ~smp_prev[i];
        assign fall_w = ~smp_cur[i] & smp_prev[i];
        assign lvl_w  = pol_high[i] ? smp_cur[i] : ~smp_cur[i];

        // Select the trigger condition configured for this line.
        always_comb begin
            if (kind_edge[i]) hit[i] = pol_high[i] ? rise_w : fall_w;
            else              hit[i] = lvl_w;
        end
    end
endmodule

// File: rtl/gpio_irq_latch.sv
// Sticky status bits with write-1-to-clear and the level summary interrupt.
// Assumes a same-cycle hit must win over a clear of the same bit.
module gpio_irq_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] ien,
    output logic [N-1:0] stat_q,
    output logic         irq_out
);
    logic [N-1:0] clr_eff;

    // Apply the clear mask only on a clear-register write.
    assign clr_eff = clr_wr ? clr_mask : '0;

    // Latch hits; clear acknowledged bits; hits take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_eff) | hit;
    end

    // Summary is any pending status with its enable set.
    assign irq_out = |(stat_q & ien);
endmodule

// File: rtl/gpio_cfg_regs.sv
// Configuration registers written through the register port.
// Assumes only the low N bits of wdata are meaningful; the rest are dropped.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [N-1:0]      drive_q,
    output logic [N-1:0]      oen_q,
    output logic [N-1:0]      ien_q,
    output logic [N-1:0]      kind_q,
    output logic [N-1:0]      pol_q,
    output logic              clr_wr,
    output logic [N-1:0]      clr_mask
);
    logic [N-1:0] wd;
    assign wd = wdata[N-1:0];

    if (N < REG_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^wdata[REG_W-1:N];
    end

    // Decode a clear write for the status latch.
    assign clr_wr   = wr_en && (reg_addr_e'(addr) == RA_CLR);
    assign clr_mask = wd;

    // Update the addressed configuration register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= '0;
            oen_q   <= '0;
            ien_q   <= '0;
            kind_q  <= '0;
            pol_q   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_DRIVE: drive_q <= wd;
                RA_OEN:   oen_q   <= wd;
                RA_IEN:   ien_q   <= wd;
                RA_KIND:  kind_q  <= wd;
                RA_POL:   pol_q   <= wd;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// GPIO bank top: pin drive, synchronized readback and interrupt detection.
// Assumes NUM_LINES <= 32; unused upper register bits read as zero.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);
    localparam int N = NUM_LINES;

    logic [N-1:0] smp_cur, smp_prev, trig_vec, stat_q;
    logic [N-1:0] drive_q, oen_q, ien_q, kind_q, pol_q, clr_mask;
    logic         clr_wr;
    logic [N-1:0] rd_sel;
    logic [REG_W-1:0] rd_word;

    gpio_in_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .smp_cur(smp_cur), .smp_prev(smp_prev)
    );

    gpio_cfg_regs #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .drive_q(drive_q), .oen_q(oen_q), .ien_q(ien_q), .kind_q(kind_q),
        .pol_q(pol_q), .clr_wr(clr_wr), .clr_mask(clr_mask)
    );

    gpio_trig_detect #(.N(N)) u_det (
        .smp_cur(smp_cur), .smp_prev(smp_prev),
        .kind_edge(kind_q), .pol_high(pol_q), .hit(trig_vec)
    );

    gpio_irq_latch #(.N(N)) u_lat (
        .clk(clk), .rst_n(rst_n), .hit(trig_vec), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .ien(ien_q), .stat_q(stat_q), .irq_out(irq_out)
    );

    assign pin_out = drive_q;
    assign pin_oe  = oen_q;

    // Select the register addressed by a read.
    always_comb begin
        case (reg_addr_e'(addr))
            RA_LEVEL: rd_sel = smp_cur;
            RA_DRIVE: rd_sel = drive_q;
            RA_OEN:   rd_sel = oen_q;
            RA_STAT:  rd_sel = stat_q;
            RA_IEN:   rd_sel = ien_q;
            RA_KIND:  rd_sel = kind_q;
            RA_POL:   rd_sel = pol_q;
            default:  rd_sel = '0;
        endcase
    end

    // Zero-extend the selected lines to the port width.
    always_comb begin
        rd_word         = '0;
        rd_word[N-1:0]  = rd_sel;
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Property checker for the GPIO bank, attached to every instance by bind.
// Assumes it observes internal hit, status and enable vectors of the top.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      clr_bits,
    input logic [N-1:0]      trig_vec,
    input logic [N-1:0]      stat_q,
    input logic [N-1:0]      ien_q,
    input logic [N-1:0]      pin_oe,
    input logic              irq_out
);
    logic clr_hit;
    assign clr_hit = wr_en && (addr == RA_CLR);

    // R4
    trig_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_vec != '0) |=> ((stat_q & $past(trig_vec)) == $past(trig_vec)));

    // R9
    trig_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && ((trig_vec & clr_bits) != '0))
            |=> ((stat_q & $past(trig_vec & clr_bits)) == $past(trig_vec & clr_bits)));

    // R5
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((stat_q & $past(clr_bits & ~trig_vec)) == '0));

    // R7
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_out);

    // R8
    irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq_out);

    // R1
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == RA_OEN) |=> $stable(pin_oe));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .clr_bits(wdata[NUM_LINES-1:0]), .trig_vec(trig_vec), .stat_q(stat_q),
    .ien_q(ien_q), .pin_oe(pin_oe), .irq_out(irq_out)
);

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
    localparam int NL = 24;
    localparam logic [31:0] LMASK = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out, pin_oe;
    logic          irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    gpio_irq_bank #(.NUM_LINES(NL)) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // {addr, write data, expected readback}
    localparam logic [66:0] VEC_TAB [0:7] = '{
        {3'd1, 32'hA5A5_A5A5, 32'h00A5_A5A5},
        {3'd1, 32'hFFFF_FFFF, 32'h00FF_FFFF},
        {3'd2, 32'h0F0F_00FF, 32'h000F_00FF},
        {3'd5, 32'h1234_5678, 32'h0034_5678},
        {3'd5, 32'h0000_0000, 32'h0000_0000},
        {3'd6, 32'hFFFF_FFFF, 32'h00FF_FFFF},
        {3'd7, 32'hFFFF_FFFF, 32'h00FF_FFFF},
        {3'd4, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(4);
        // R10 reset state
        check("R10 pin_oe", 32'(pin_oe), 32'h0);
        check("R10 pin_out", 32'(pin_out), 32'h0);
        check("R10 irq_out", 32'(irq_out), 32'h0);
        check("R10 rdata", rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R7 default config is low-level: low pins latch
        rd(3'd3, rv);
        check("R7 default low-level status", rv, LMASK);

        // R2 R11 R1 table walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC_TAB[i][66:64], VEC_TAB[i][63:32]);
            if (VEC_TAB[i][66:64] == 3'd1) check("R1 pin_out", 32'(pin_out), VEC_TAB[i][31:0]);
            if (VEC_TAB[i][66:64] == 3'd2) check("R1 pin_oe", 32'(pin_oe), VEC_TAB[i][31:0]);
            rd(VEC_TAB[i][66:64], rv);
            check("R2 R11 readback", rv, VEC_TAB[i][31:0]);
        end
        rd(3'd3, rv);
        check("R5 status after clear", rv, 32'h0);

        // R3 R4 R6 rising edges with interrupts disabled
        pin_in = 24'h00C3A5;
        idle(3);
        rd(3'd0, rv);
        check("R3 input readback", rv, 32'h0000_C3A5);
        rd(3'd3, rv);
        check("R4 R6 status latched while disabled", rv, 32'h0000_C3A5);
        check("R8 irq low with enable zero", 32'(irq_out), 32'h0);
        wr(3'd5, 32'h1);
        check("R8 irq high on enabled pending", 32'(irq_out), 32'h1);
        wr(3'd5, 32'h2);
        check("R8 irq low on enabled idle line", 32'(irq_out), 32'h0);
        wr(3'd4, 32'h0000_0005);
        rd(3'd3, rv);
        check("R5 partial clear", rv, 32'h0000_C3A0);
        pin_in = '0;
        idle(4);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd3, rv);
        check("R6 falling ignored with polarity 1", rv, 32'h0);

        // R6 falling-edge line
        wr(3'd7, 32'h00FF_FFEF);
        pin_in[4] = 1'b1;
        idle(4);
        rd(3'd3, rv);
        check("R6 rising ignored with polarity 0", rv, 32'h0);
        pin_in[4] = 1'b0;
        idle(4);
        rd(3'd3, rv);
        check("R6 falling edge latched", rv, 32'h0000_0010);
        wr(3'd4, 32'h10);
        wr(3'd7, 32'h00FF_FFFF);

        // R7 level-high on line 8
        wr(3'd6, 32'h00FF_FEFF);
        pin_in[8] = 1'b1;
        idle(4);
        pin_in[8] = 1'b0;
        idle(4);
        rd(3'd3, rv);
        check("R7 level event held after pin idle", rv, 32'h0000_0100);
        wr(3'd4, 32'h100);
        rd(3'd3, rv);
        check("R7 level cleared", rv, 32'h0);

        // R9 clear while level still active
        pin_in[8] = 1'b1;
        idle(4);
        wr(3'd4, 32'h100);
        rd(3'd3, rv);
        check("R9 active level beats clear", rv, 32'h0000_0100);
        pin_in[8] = 1'b0;
        idle(4);
        wr(3'd4, 32'h100);

        // R9 edge hit and clear sampled on the same edge
        @(negedge clk); pin_in[9] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 32'h200;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd3, rv);
        check("R9 edge hit beats same-cycle clear", rv, 32'h0000_0200);
        wr(3'd4, 32'h200);
        rd(3'd3, rv);
        check("R5 later clear empties bit", rv, 32'h0);

        finish_run();
    end
endmodule